// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block holds recently used virtual-to-physical page mappings for a 32-bit virtual address space that is cut into 8 KB pages. Each lookup supplies a virtual address and an access kind, which is read, write or instruction fetch. One clock later the block returns one of two results. The first is the physical address, formed from the stored frame number and the unchanged 13-bit page offset. The second is a fault code that echoes the faulting address and access kind. The three fault causes are: no entry for the page, an entry whose valid flag is clear, and a store to a page without write permission.

Every entry is compared against the page number at the same time. A refill port writes new mappings. If the refilled page is already held, the refill replaces that entry. Otherwise it takes the lowest entry that is not valid. When all entries are valid, a rotating pointer chooses the victim and skips the entry that was hit most recently. A flush input clears every valid flag in one cycle when the address space changes. Each entry keeps a referenced flag and a modified flag. The hardware sets these flags itself whenever a reference through the entry completes. Walking the page tables and servicing faults are left to the surrounding logic.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup's result appears on the response outputs in the clock cycle after the lookup is presented. On a hit the physical address is the entry's frame number in bits 31..13 and the lookup's bits 12..0 unchanged.
- R2: A lookup whose page number (bits 31..13) is held by no entry returns fault code 1. Every fault response carries the full faulting virtual address and the access kind (0 read, 1 write, 2 fetch).
- R3: A lookup whose page is held only by an entry with its valid flag clear returns fault code 2.
- R4: A write (kind 1) through a valid entry whose write permission is clear returns fault code 3, while reads and fetches through it succeed. Any fault response drives the physical address, modified and referenced outputs to 0.
- R5: A completed write sets the entry's modified flag. A hit response reports the modified flag as it stood before that reference.
- R6: Any completed reference sets the entry's referenced flag, and a faulting reference changes neither flag. A hit response reports the referenced flag as it stood before that reference.
- R7: A flush clears all valid flags, and lookups from the next cycle onward return fault code 2 for pages that were held. A refill on the flush cycle still installs a valid entry.
- R8: A refill of a page number already held overwrites that entry's frame, permission and valid flag and clears its modified and referenced flags, so no duplicate is made.
- R9: A refill and a lookup in the same cycle leave the lookup with the contents from before the refill. The refilled mapping is visible from the next cycle.
- R10: With no matching entry, a refill takes the lowest-numbered entry whose valid flag is clear. When every entry is valid it takes the rotating pointer's entry, moving one further on if that entry was the most recently hit. The pointer then moves past the victim.
- R11: After reset no response is valid, the fault code is 0, and no entry holds any page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_mode | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| rf_valid | input | 1 | Refill request present |
| rf_vpn | input | 19 | Page number to install |
| rf_pfn | input | 19 | Frame number to install |
| rf_wr_ok | input | 1 | Write permission of the new entry |
| rf_live | input | 1 | Valid flag of the new entry |
| flush | input | 1 | Clear all valid flags |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 invalid entry, 3 write protection |
| rsp_fault_vaddr | output | 32 | Faulting virtual address (0 when no fault) |
| rsp_fault_mode | output | 2 | Faulting access kind (0 when no fault) |
| rsp_dirty | output | 1 | Modified flag before this hit |
| rsp_ref | output | 1 | Referenced flag before this hit |

## Verification
Every lookup result is registered, so it is due exactly one clock after the request. The bench drives each request on a falling edge and reads the result on the next falling edge, one full period after the capturing rising edge. Refills and flushes also take effect at the rising edge that follows them. Their effect is therefore checked through a lookup issued no earlier than the next cycle, and the same-cycle collision case deliberately reads the old contents first. Flag updates from one reference show up in the response of the following reference to the same page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned XL_VA_W    = 32;
    localparam int unsigned XL_OFS_W   = 13;
    localparam int unsigned XL_PFN_W   = 19;
    localparam int unsigned XL_ENTRIES = 48;

    // Access kinds presented with a lookup; code 3 behaves as a read.
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_mode_e;

    // Fault codes returned with a response.
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISS    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    // Per-entry state bits.
    typedef struct packed {
        logic loaded;   // entry holds a page number at all
        logic valid;    // mapping may be used
        logic wr_ok;    // stores permitted
        logic dirty;    // a store has completed through this entry
        logic refd;     // a reference has completed through this entry
    } ent_flags_t;

    function automatic logic is_store(input logic [1:0] mode);
        return mode == ACC_WRITE;
    endfunction

endpackage

// File: rtl/xlat_match.sv
// Parallel comparison of one probe key against every stored key.
module xlat_match #(
    parameter int N     = 48,
    parameter int KEY_W = 19
) (
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [N-1:0]            live,
    input  logic [KEY_W-1:0]        probe,
    output logic [N-1:0]            hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = live[g] && (keys[g] == probe);
    end
endmodule

// File: rtl/xlat_penc.sv
// Lowest-index-first priority encoder.
module xlat_penc #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_nlu.sv
// Rotating victim pointer that steps over the most recently hit entry.
module xlat_nlu #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             last_vld,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] ptr_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(N - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    always_comb begin
        victim = ptr_q;
        if (last_vld && ptr_q == last_idx) victim = step(ptr_q);
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= '0;
        else if (take) ptr_q <= step(victim);
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int VA_W    = XL_VA_W,
    parameter int OFS_W   = XL_OFS_W,
    parameter int PFN_W   = XL_PFN_W,
    parameter int ENTRIES = XL_ENTRIES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [1:0]            lk_mode,
    input  logic                  rf_valid,
    input  logic [VA_W-OFS_W-1:0] rf_vpn,
    input  logic [PFN_W-1:0]      rf_pfn,
    input  logic                  rf_wr_ok,
    input  logic                  rf_live,
    input  logic                  flush,
    output logic                  rsp_valid,
    output logic [PFN_W+OFS_W-1:0] rsp_paddr,
    output logic [1:0]            rsp_fault,
    output logic [VA_W-1:0]       rsp_fault_vaddr,
    output logic [1:0]            rsp_fault_mode,
    output logic                  rsp_dirty,
    output logic                  rsp_ref
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PA_W  = PFN_W + OFS_W;
    localparam int IDX_W = $clog2(ENTRIES);

    // Entry storage
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    ent_flags_t                    flg_q [ENTRIES];
    logic [ENTRIES-1:0]            loaded_v, valid_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign loaded_v[g] = flg_q[g].loaded;
        assign valid_v[g]  = flg_q[g].valid;
    end

    // Lookup path
    logic [VPN_W-1:0]   lk_vpn;
    logic [OFS_W-1:0]   lk_ofs;
    logic [ENTRIES-1:0] lk_match, lk_hit_v;
    logic [IDX_W-1:0]   hit_idx;
    logic               hit_any, tag_any, store, prot, done;
    fault_e             fault_d;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
    assign lk_ofs = lk_vaddr[OFS_W-1:0];

    xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_lk_match (
        .keys(tag_q), .live(loaded_v), .probe(lk_vpn), .hit(lk_match)
    );

    assign lk_hit_v = lk_match & valid_v;

    xlat_penc #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
        .vec(lk_hit_v), .idx(hit_idx), .any(hit_any)
    );

    assign tag_any = |lk_match;
    assign store   = is_store(lk_mode);
    assign prot    = hit_any && store && !flg_q[hit_idx].wr_ok;
    assign done    = lk_valid && hit_any && !prot;

    always_comb begin
        if (hit_any)      fault_d = prot ? FLT_PROT : FLT_NONE;
        else if (tag_any) fault_d = FLT_INVALID;
        else              fault_d = FLT_MISS;
    end

    // Refill placement
    logic [ENTRIES-1:0] rf_match;
    logic [IDX_W-1:0]   rf_m_idx, free_idx, nlu_victim, rf_idx;
    logic               rf_m_any, free_any, nlu_take;
    logic [IDX_W-1:0]   last_q;
    logic               last_vld_q;

    xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_rf_match (
        .keys(tag_q), .live(loaded_v), .probe(rf_vpn), .hit(rf_match)
    );

    xlat_penc #(.N(ENTRIES), .IDX_W(IDX_W)) u_rf_enc (
        .vec(rf_match), .idx(rf_m_idx), .any(rf_m_any)
    );

    xlat_penc #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
        .vec(~valid_v), .idx(free_idx), .any(free_any)
    );

    assign nlu_take = rf_valid && !rf_m_any && !free_any;

    xlat_nlu #(.N(ENTRIES), .IDX_W(IDX_W)) u_nlu (
        .clk(clk), .rst(rst), .take(nlu_take),
        .last_vld(last_vld_q), .last_idx(last_q), .victim(nlu_victim)
    );

    always_comb begin
        if (rf_m_any)      rf_idx = rf_m_idx;
        else if (free_any) rf_idx = free_idx;
        else               rf_idx = nlu_victim;
    end

    // Most recently hit entry
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q     <= '0;
            last_vld_q <= 1'b0;
        end else if (done) begin
            last_q     <= hit_idx;
            last_vld_q <= 1'b1;
        end
    end

    // Flag state: flush, then hardware flag updates, then refill (last wins)
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                flg_q[i] <= '0;
            end else begin
                if (flush) flg_q[i].valid <= 1'b0;
                if (done && hit_idx == IDX_W'(i)) begin
                    flg_q[i].refd <= 1'b1;
                    if (store) flg_q[i].dirty <= 1'b1;
                end
                if (rf_valid && rf_idx == IDX_W'(i)) begin
                    flg_q[i] <= '{loaded: 1'b1, valid: rf_live, wr_ok: rf_wr_ok,
                                  dirty: 1'b0, refd: 1'b0};
                end
            end
        end
    end

    // Key and frame storage carries no reset; the loaded flag qualifies it
    always_ff @(posedge clk) begin
        if (rf_valid) begin
            tag_q[rf_idx] <= rf_vpn;
            pfn_q[rf_idx] <= rf_pfn;
        end
    end

    // Registered response
    fault_e fault_q;
    logic   ok;
    assign ok = (fault_d == FLT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            fault_q         <= FLT_NONE;
            rsp_paddr       <= '0;
            rsp_fault_vaddr <= '0;
            rsp_fault_mode  <= '0;
            rsp_dirty       <= 1'b0;
            rsp_ref         <= 1'b0;
        end else begin
            rsp_valid       <= lk_valid;
            fault_q         <= lk_valid ? fault_d : FLT_NONE;
            rsp_paddr       <= (lk_valid && ok) ? {pfn_q[hit_idx], lk_ofs} : PA_W'(0);
            rsp_fault_vaddr <= (lk_valid && !ok) ? lk_vaddr : '0;
            rsp_fault_mode  <= (lk_valid && !ok) ? lk_mode : 2'd0;
            rsp_dirty       <= done && flg_q[hit_idx].dirty;
            rsp_ref         <= done && flg_q[hit_idx].refd;
        end
    end

    assign rsp_fault = fault_q;

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFS_W = 13,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic [1:0]       lk_mode,
    input logic             rf_valid,
    input logic             flush,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault,
    input logic [VA_W-1:0]  rsp_fault_vaddr,
    input logic [1:0]       rsp_fault_mode,
    input logic             rsp_dirty,
    input logic             rsp_ref,
    input logic             nlu_take,
    input logic             last_vld,
    input logic [IDX_W-1:0] last_idx,
    input logic [IDX_W-1:0] victim
);
    assert_resp_due_R1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    assert_no_stray_resp_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0]));

    assert_fault_echo_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'd0) |-> (rsp_fault_vaddr == $past(lk_vaddr) && rsp_fault_mode == $past(lk_mode)));

    assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'd0) |-> (rsp_paddr == '0 && !rsp_dirty && !rsp_ref));

    assert_prot_on_store_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault == 2'd3) |-> rsp_fault_mode == 2'd1);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && !$past(rf_valid) && lk_valid) |=> rsp_fault != 2'd0);

    assert_victim_spares_last_R10: assert property (@(posedge clk) disable iff (rst)
        (nlu_take && last_vld) |-> victim != last_idx);
endmodule

bind xlat_buffer xlat_buffer_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_mode(lk_mode),
    .rf_valid(rf_valid), .flush(flush), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_vaddr(rsp_fault_vaddr), .rsp_fault_mode(rsp_fault_mode),
    .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref), .nlu_take(nlu_take),
    .last_vld(last_vld_q), .last_idx(last_q), .victim(nlu_victim)
);

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_mode = '0;
    logic        rf_valid = 1'b0;
    logic [18:0] rf_vpn = '0;
    logic [18:0] rf_pfn = '0;
    logic        rf_wr_ok = 1'b0;
    logic        rf_live = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_fault_vaddr;
    logic [1:0]  rsp_fault_mode;
    logic        rsp_dirty;
    logic        rsp_ref;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xlat_buffer uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_mode(lk_mode),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_wr_ok(rf_wr_ok),
        .rf_live(rf_live), .flush(flush), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_fault_vaddr(rsp_fault_vaddr),
        .rsp_fault_mode(rsp_fault_mode), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
    );

    // {vaddr, mode, fault, paddr, dirty_before, ref_before}
    localparam logic [69:0] VECS [9] = '{
        {32'h0000_2ABC, 2'd0, 2'd0, 32'h2468_AABC, 1'b0, 1'b0},
        {32'h0000_3FFF, 2'd1, 2'd0, 32'h2468_BFFF, 1'b0, 1'b1},
        {32'h0000_2000, 2'd0, 2'd0, 32'h2468_A000, 1'b1, 1'b1},
        {32'hFFFF_F234, 2'd2, 2'd0, 32'h0157_9234, 1'b0, 1'b0},
        {32'hFFFF_E000, 2'd1, 2'd3, 32'h0000_0000, 1'b0, 1'b0},
        {32'hFFFF_E010, 2'd0, 2'd0, 32'h0157_8010, 1'b0, 1'b1},
        {32'h0020_0000, 2'd0, 2'd2, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0000_4000, 2'd0, 2'd1, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0020_0008, 2'd1, 2'd2, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] m);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_mode = m;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [18:0] vpn, input logic [18:0] pfn,
                          input logic wr, input logic live);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn; rf_wr_ok = wr; rf_live = live;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 reset fault", 64'(rsp_fault), 64'd0);

        // Setup mappings
        refill(19'h00001, 19'h12345, 1'b1, 1'b1);
        refill(19'h7FFFF, 19'h00ABC, 1'b0, 1'b1);
        refill(19'h00100, 19'h54321, 1'b1, 1'b0);

        // Table walk
        for (int k = 0; k < 9; k++) begin
            logic [31:0] va;
            logic [1:0]  md, ef;
            logic [31:0] pa;
            string ftag;
            va = VECS[k][69:38]; md = VECS[k][37:36]; ef = VECS[k][35:34]; pa = VECS[k][33:2];
            lookup(va, md);
            case (ef)
                2'd0: ftag = "R1";
                2'd1: ftag = "R2";
                2'd2: ftag = "R3";
                default: ftag = "R4";
            endcase
            check($sformatf("%s vec%0d fault", ftag, k), 64'(rsp_fault), 64'(ef));
            check($sformatf("R1 vec%0d paddr", k), 64'(rsp_paddr), 64'(pa));
            check($sformatf("R5 vec%0d dirty", k), 64'(rsp_dirty), 64'(VECS[k][1]));
            check($sformatf("R6 vec%0d ref", k), 64'(rsp_ref), 64'(VECS[k][0]));
            if (ef != 2'd0) begin
                check($sformatf("R2 vec%0d fault vaddr", k), 64'(rsp_fault_vaddr), 64'(va));
                check($sformatf("R2 vec%0d fault mode", k), 64'(rsp_fault_mode), 64'(md));
            end
        end

        // R8: overwrite an existing page, flags cleared
        refill(19'h00001, 19'h0000F, 1'b1, 1'b1);
        lookup(32'h0000_2005, 2'd0);
        check("R8 overwrite paddr", 64'(rsp_paddr), 64'h0001_E005);
        check("R8 overwrite dirty cleared", 64'(rsp_dirty), 64'd0);
        check("R8 overwrite ref cleared", 64'(rsp_ref), 64'd0);

        // R9: refill and lookup in one cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = 32'h0000_6000; lk_mode = 2'd0;
        rf_valid = 1'b1; rf_vpn = 19'h00003; rf_pfn = 19'h00007; rf_wr_ok = 1'b1; rf_live = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; rf_valid = 1'b0;
        check("R9 same-cycle sees old", 64'(rsp_fault), 64'd1);
        lookup(32'h0000_6004, 2'd0);
        check("R9 next-cycle hit", 64'(rsp_fault), 64'd0);
        check("R9 next-cycle paddr", 64'(rsp_paddr), 64'h0000_E004);

        // R7: flush
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup(32'h0000_2000, 2'd0);
        check("R7 flushed page invalid", 64'(rsp_fault), 64'd2);
        lookup(32'h0000_6000, 2'd2);
        check("R7 flushed page invalid fetch", 64'(rsp_fault), 64'd2);
        refill(19'h00001, 19'h00022, 1'b1, 1'b1);
        lookup(32'h0000_2000, 2'd0);
        check("R7 refill after flush", 64'(rsp_paddr), 64'h0004_4000);

        // R11: second reset empties everything
        do_reset();
        @(negedge clk);
        check("R11 after reset rsp_valid", 64'(rsp_valid), 64'd0);
        lookup(32'h0000_2000, 2'd0);
        check("R11 entries empty", 64'(rsp_fault), 64'd1);

        // R10: fill, then replace with the pointer
        for (int i = 0; i < 48; i++) refill(19'(32'h100 + i), 19'(i), 1'b1, 1'b1);
        lookup(32'h0020_0000, 2'd0);
        check("R10 entry0 hit", 64'(rsp_fault), 64'd0);
        refill(19'h00200, 19'h00055, 1'b1, 1'b1);
        lookup(32'h0020_0000, 2'd0);
        check("R10 recent entry kept", 64'(rsp_fault), 64'd0);
        lookup(32'h0020_2000, 2'd0);
        check("R10 next entry evicted", 64'(rsp_fault), 64'd1);
        lookup(32'h0040_0000, 2'd0);
        check("R10 new page present", 64'(rsp_paddr), 64'h000A_A000);
        lookup(32'h0020_4000, 2'd0);
        check("R10 entry2 hit", 64'(rsp_fault), 64'd0);
        refill(19'h00201, 19'h00066, 1'b1, 1'b1);
        lookup(32'h0020_4000, 2'd0);
        check("R10 second recent kept", 64'(rsp_fault), 64'd0);
        lookup(32'h0020_6000, 2'd0);
        check("R10 second victim evicted", 64'(rsp_fault), 64'd1);
        lookup(32'h0040_2000, 2'd0);
        check("R10 second new page", 64'(rsp_paddr), 64'h000C_C000);

        finish_run();
    end
endmodule